// File: doc/BRIEF.md
# In-band XON/XOFF flow controller

This block sits beside a serial receiver, its receive queue and the transmitter, and carries out flow control inside the data stream. It watches the receive queue fill level against two programmable marks. When the level climbs past the upper mark it asks the transmitter for one stop character. When the level later sinks below the lower mark it asks for one resume character. In the other direction it screens every received byte against the programmed stop and resume codes. A stop code pauses the local transmitter's data and a resume code releases it. Each match raises a one-cycle interrupt pulse. Matched codes can optionally be kept out of the receive queue.

Software can also request a stop or resume character directly; the request stays visible as pending until the character has been handed to the transmitter. Two force inputs override whatever the far end has signalled. The transmitter offers a slot input at each character boundary. In that cycle the block loads either a flow character, ahead of any queued data, or the next queued data byte, or nothing.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, tx_load, txq_pop, irq_xon, irq_xoff, pend_xon, pend_xoff and tx_halted are all 0, and the last flow character is taken to be a resume character.
- R2: With cfg_en set, the upper mark is {cfg_hi_msb, cfg_hi_lsb} and the lower mark is {cfg_lo_msb, cfg_lo_lsb}. A level strictly above the upper mark wants a stop character unless the last flow character sent was a stop. A level strictly below the lower mark wants a resume character only if the last flow character sent was a stop.
- R3: With cfg_en set, a received byte equal to cfg_xoff_char pauses data from the next cycle on and pulses irq_xoff for exactly the cycle after it arrives. A byte equal to cfg_xon_char releases data and pulses irq_xon in the same way. When both codes are equal, the byte counts as a stop.
- R4: txq_pop is never asserted while tx_halted is 1. tx_halted shows the effective pause state.
- R5: With cfg_en and cfg_strip set, a received stop or resume code does not raise fifo_wr. All other received bytes are written with fifo_wdata equal to rx_data.
- R6: A pulse on sw_send_xoff or sw_send_xon sets pend_xoff or pend_xon one cycle later, whether or not cfg_en is set. The pending bit clears the cycle after that character is loaded, unless a new pulse arrives in the load cycle.
- R7: tx_load is asserted only in a cycle with tx_slot set. Within such a cycle the priority is a stop character (pending or wanted), then a resume character, then a queued byte if txq_valid is set and the block is not halted. txq_pop is asserted only when the queued byte is the one loaded.
- R8: With cfg_en clear, no automatic flow character is wanted, received codes do not pause data, raise no interrupt and are written to the queue as data, and the far-end pause state is cleared.
- R9: force_stop holds tx_halted at 1. force_run, when force_stop is clear, holds tx_halted at 0. Both override the received pause state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Enables all automatic flow behaviour |
| cfg_strip | input | 1 | Keep matched flow codes out of the receive queue |
| cfg_xon_char | input | 8 | Resume character code |
| cfg_xoff_char | input | 8 | Stop character code |
| cfg_hi_lsb | input | 8 | Upper mark, low 8 bits |
| cfg_hi_msb | input | 2 | Upper mark, high 2 bits |
| cfg_lo_lsb | input | 8 | Lower mark, low 8 bits |
| cfg_lo_msb | input | 2 | Lower mark, high 2 bits |
| rx_level | input | 10 | Current receive queue fill level |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| fifo_wr | output | 1 | Write strobe to the receive queue |
| fifo_wdata | output | 8 | Byte written to the receive queue |
| sw_send_xon | input | 1 | Software pulse requesting a resume character |
| sw_send_xoff | input | 1 | Software pulse requesting a stop character |
| pend_xon | output | 1 | Software resume request still pending |
| pend_xoff | output | 1 | Software stop request still pending |
| force_stop | input | 1 | Hold the transmitter's data paused |
| force_run | input | 1 | Hold the transmitter's data running |
| tx_slot | input | 1 | Transmitter can accept a character this cycle |
| txq_valid | input | 1 | Transmit queue holds a byte |
| txq_data | input | 8 | Head byte of the transmit queue |
| txq_pop | output | 1 | Pop the transmit queue head |
| tx_load | output | 1 | Load tx_char into the transmitter |
| tx_char | output | 8 | Character handed to the transmitter |
| tx_halted | output | 1 | Effective data pause state |
| irq_xon | output | 1 | Resume code received pulse |
| irq_xoff | output | 1 | Stop code received pulse |

## Verification
A wrong memory of the last flow character shows at the next transmitter slot: either a second stop character goes out while the level stays high, or no resume character follows when the level drops. A wrong pause state shows in the first slot after a received code as a popped byte while tx_halted is 1, or as a byte withheld while running. A stuck pending bit shows as a flow character repeated at each slot and as pend_xon or pend_xoff still high the cycle after its load. The bench runs a cycle model beside the block and compares every output in every cycle, so such a fault appears within a cycle or two of the stimulus that exposes it.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_XOFF = 2'd1,
    PICK_XON  = 2'd2,
    PICK_DATA = 2'd3
  } pick_e;

  // Slot arbitration: stop before resume before data.
  function automatic pick_e choose_slot(input logic slot, input logic want_off,
                                        input logic want_on, input logic data_ok);
    if (!slot)         return PICK_NONE;
    else if (want_off) return PICK_XOFF;
    else if (want_on)  return PICK_XON;
    else if (data_ok)  return PICK_DATA;
    else               return PICK_NONE;
  endfunction

endpackage

// File: rtl/xfc_rx_screen.sv
module xfc_rx_screen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          strip,
  input  logic [CW-1:0] xon_char,
  input  logic [CW-1:0] xoff_char,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          fifo_wr,
  output logic [CW-1:0] fifo_wdata,
  output logic          hit_xon,
  output logic          hit_xoff,
  output logic          remote_stop,
  output logic          irq_xon,
  output logic          irq_xoff
);

  logic is_flow;

  always_comb begin
    hit_xoff   = en && rx_valid && (rx_data == xoff_char);
    hit_xon    = en && rx_valid && (rx_data == xon_char) && !hit_xoff;
    is_flow    = hit_xon || hit_xoff;
    fifo_wr    = rx_valid && !(strip && is_flow);
    fifo_wdata = rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remote_stop <= 1'b0;
      irq_xon     <= 1'b0;
      irq_xoff    <= 1'b0;
    end else begin
      irq_xon  <= hit_xon;
      irq_xoff <= hit_xoff;
      if (!en)           remote_stop <= 1'b0;
      else if (hit_xoff) remote_stop <= 1'b1;
      else if (hit_xon)  remote_stop <= 1'b0;
    end
  end

  a_r5_strip_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && strip && rx_valid && ((rx_data == xon_char) || (rx_data == xoff_char))) |-> !fifo_wr);

  a_r8_pass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && rx_valid) |-> (fifo_wr && (fifo_wdata == rx_data)));

  a_r3_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_xon && irq_xoff));

  a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_xoff || irq_xon) |-> $past(rx_valid));

  a_r3_stop_latches: assert property (@(posedge clk) disable iff (!rst_n)
    hit_xoff |=> remote_stop);

endmodule

// File: rtl/xfc_level_watch.sv
module xfc_level_watch #(
  parameter int LW   = 10,
  parameter int LO_W = 8
) (
  input  logic              en,
  input  logic [LW-1:0]     level,
  input  logic [LO_W-1:0]   hi_lsb,
  input  logic [LW-LO_W-1:0] hi_msb,
  input  logic [LO_W-1:0]   lo_lsb,
  input  logic [LW-LO_W-1:0] lo_msb,
  input  logic              last_off,
  output logic              auto_off,
  output logic              auto_on
);

  localparam int HI_W = LW - LO_W;

  function automatic logic [LW-1:0] join_mark(input logic [HI_W-1:0] msb,
                                              input logic [LO_W-1:0] lsb);
    return {msb, lsb};
  endfunction

  logic [LW-1:0] upper_mark;
  logic [LW-1:0] lower_mark;
  logic          over_upper;
  logic          under_lower;

  always_comb begin
    upper_mark  = join_mark(hi_msb, hi_lsb);
    lower_mark  = join_mark(lo_msb, lo_lsb);
    over_upper  = level > upper_mark;
    under_lower = level < lower_mark;
    auto_off    = en && over_upper && !last_off;
    auto_on     = en && under_lower && last_off;
  end

endmodule

// File: rtl/xfc_tx_arbiter.sv
module xfc_tx_arbiter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot,
  input  logic          auto_off,
  input  logic          auto_on,
  input  logic          req_on,
  input  logic          req_off,
  input  logic          halt,
  input  logic          txq_valid,
  input  logic [CW-1:0] txq_data,
  input  logic [CW-1:0] xon_char,
  input  logic [CW-1:0] xoff_char,
  output logic          tx_load,
  output logic [CW-1:0] tx_char,
  output logic          txq_pop,
  output logic          pend_on,
  output logic          pend_off,
  output logic          last_off
);

  import xfc_pkg::*;

  pick_e pick;
  logic  want_off;
  logic  want_on;
  logic  sent_off;
  logic  sent_on;

  always_comb begin
    want_off = pend_off || auto_off;
    want_on  = pend_on || auto_on;
    pick     = choose_slot(slot, want_off, want_on, txq_valid && !halt);
    sent_off = (pick == PICK_XOFF);
    sent_on  = (pick == PICK_XON);
    tx_load  = (pick != PICK_NONE);
    txq_pop  = (pick == PICK_DATA);
    case (pick)
      PICK_XOFF: tx_char = xoff_char;
      PICK_XON:  tx_char = xon_char;
      PICK_DATA: tx_char = txq_data;
      default:   tx_char = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
      last_off <= 1'b0;
    end else begin
      pend_off <= req_off || (pend_off && !sent_off);
      pend_on  <= req_on  || (pend_on  && !sent_on);
      if (sent_off)     last_off <= 1'b1;
      else if (sent_on) last_off <= 1'b0;
    end
  end

  a_r4_no_pop_halted: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> !halt);

  a_r7_load_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> slot);

  a_r7_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && (pend_off || auto_off)) |-> (tx_load && (tx_char == xoff_char) && !txq_pop));

  a_r2_no_double_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_off && !pend_off) |-> !last_off);

  a_r6_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_off && !req_off) |=> !pend_off);

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
  parameter int CW        = 8,
  parameter int LW        = 10,
  parameter int LO_W      = 8,
  parameter bit STOP_WINS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_strip,
  input  logic [CW-1:0]       cfg_xon_char,
  input  logic [CW-1:0]       cfg_xoff_char,
  input  logic [LO_W-1:0]     cfg_hi_lsb,
  input  logic [LW-LO_W-1:0]  cfg_hi_msb,
  input  logic [LO_W-1:0]     cfg_lo_lsb,
  input  logic [LW-LO_W-1:0]  cfg_lo_msb,
  input  logic [LW-1:0]       rx_level,
  input  logic                rx_valid,
  input  logic [CW-1:0]       rx_data,
  output logic                fifo_wr,
  output logic [CW-1:0]       fifo_wdata,
  input  logic                sw_send_xon,
  input  logic                sw_send_xoff,
  output logic                pend_xon,
  output logic                pend_xoff,
  input  logic                force_stop,
  input  logic                force_run,
  input  logic                tx_slot,
  input  logic                txq_valid,
  input  logic [CW-1:0]       txq_data,
  output logic                txq_pop,
  output logic                tx_load,
  output logic [CW-1:0]       tx_char,
  output logic                tx_halted,
  output logic                irq_xon,
  output logic                irq_xoff
);

  logic hit_xon;
  logic hit_xoff;
  logic remote_stop;
  logic last_off;
  logic auto_off;
  logic auto_on;
  logic halt_eff;

  xfc_rx_screen #(.CW(CW)) u_screen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_en),
    .strip      (cfg_strip),
    .xon_char   (cfg_xon_char),
    .xoff_char  (cfg_xoff_char),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .hit_xon    (hit_xon),
    .hit_xoff   (hit_xoff),
    .remote_stop(remote_stop),
    .irq_xon    (irq_xon),
    .irq_xoff   (irq_xoff)
  );

  xfc_level_watch #(.LW(LW), .LO_W(LO_W)) u_level (
    .en       (cfg_en),
    .level    (rx_level),
    .hi_lsb   (cfg_hi_lsb),
    .hi_msb   (cfg_hi_msb),
    .lo_lsb   (cfg_lo_lsb),
    .lo_msb   (cfg_lo_msb),
    .last_off (last_off),
    .auto_off (auto_off),
    .auto_on  (auto_on)
  );

  generate
    if (STOP_WINS) begin : g_stop_wins
      always_comb halt_eff = force_stop || (!force_run && remote_stop);
    end else begin : g_run_wins
      always_comb halt_eff = !force_run && (force_stop || remote_stop);
    end
  endgenerate

  assign tx_halted = halt_eff;

  xfc_tx_arbiter #(.CW(CW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (tx_slot),
    .auto_off  (auto_off),
    .auto_on   (auto_on),
    .req_on    (sw_send_xon),
    .req_off   (sw_send_xoff),
    .halt      (halt_eff),
    .txq_valid (txq_valid),
    .txq_data  (txq_data),
    .xon_char  (cfg_xon_char),
    .xoff_char (cfg_xoff_char),
    .tx_load   (tx_load),
    .tx_char   (tx_char),
    .txq_pop   (txq_pop),
    .pend_on   (pend_xon),
    .pend_off  (pend_xoff),
    .last_off  (last_off)
  );

  a_r9_force_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (STOP_WINS && force_stop) |-> tx_halted);

  a_r9_force_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (force_run && !force_stop) |-> !tx_halted);

  a_r8_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && rx_valid) |=> !(irq_xon || irq_xoff));

endmodule

// File: tb/xonxoff_flow_ctrl_bench.sv
module xonxoff_flow_ctrl_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       cfg_en, cfg_strip;
  logic [7:0] cfg_xon_char, cfg_xoff_char, cfg_hi_lsb, cfg_lo_lsb;
  logic [1:0] cfg_hi_msb, cfg_lo_msb;
  logic [9:0] rx_level;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       fifo_wr;
  logic [7:0] fifo_wdata;
  logic       sw_send_xon, sw_send_xoff, pend_xon, pend_xoff;
  logic       force_stop, force_run, tx_slot, txq_valid;
  logic [7:0] txq_data, tx_char;
  logic       txq_pop, tx_load, tx_halted, irq_xon, irq_xoff;

  int checks = 0;
  int fails  = 0;

  xonxoff_flow_ctrl u_xonxoff_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_strip(cfg_strip),
    .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
    .cfg_hi_lsb(cfg_hi_lsb), .cfg_hi_msb(cfg_hi_msb),
    .cfg_lo_lsb(cfg_lo_lsb), .cfg_lo_msb(cfg_lo_msb),
    .rx_level(rx_level), .rx_valid(rx_valid), .rx_data(rx_data),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .sw_send_xon(sw_send_xon), .sw_send_xoff(sw_send_xoff),
    .pend_xon(pend_xon), .pend_xoff(pend_xoff),
    .force_stop(force_stop), .force_run(force_run),
    .tx_slot(tx_slot), .txq_valid(txq_valid), .txq_data(txq_data),
    .txq_pop(txq_pop), .tx_load(tx_load), .tx_char(tx_char),
    .tx_halted(tx_halted), .irq_xon(irq_xon), .irq_xoff(irq_xoff)
  );

  // Reference state, kept from the requirements.
  bit m_far_stop, m_sent_stop, m_p_on, m_p_off, m_i_on, m_i_off;

  function automatic bit upper_hit();
    return cfg_en && (rx_level > {cfg_hi_msb, cfg_hi_lsb}) && !m_sent_stop;
  endfunction

  function automatic bit lower_hit();
    return cfg_en && (rx_level < {cfg_lo_msb, cfg_lo_lsb}) && m_sent_stop;
  endfunction

  function automatic bit paused();
    if (force_stop) return 1'b1;
    if (force_run)  return 1'b0;
    return m_far_stop;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit w_off, w_on, e_load, e_pop, e_wr, s_off, s_on;
    bit got_off, got_on;
    logic [7:0] e_char;
    #2;
    w_off   = m_p_off || upper_hit();
    w_on    = m_p_on  || lower_hit();
    e_pop   = tx_slot && !w_off && !w_on && txq_valid && !paused();
    e_load  = tx_slot && (w_off || w_on || e_pop);
    e_char  = w_off ? cfg_xoff_char : (w_on ? cfg_xon_char : txq_data);
    got_off = cfg_en && rx_valid && (rx_data == cfg_xoff_char);
    got_on  = cfg_en && rx_valid && (rx_data == cfg_xon_char) && !got_off;
    e_wr    = rx_valid && !(cfg_strip && (got_off || got_on));
    check("R7 tx_load", tx_load, e_load);
    if (e_load) check("R2 R7 tx_char", tx_char, e_char);
    check("R4 txq_pop", txq_pop, e_pop);
    check("R4 R9 tx_halted", tx_halted, paused());
    check("R5 R8 fifo_wr", fifo_wr, e_wr);
    if (e_wr) check("R5 fifo_wdata", fifo_wdata, rx_data);
    check("R3 irq_xoff", irq_xoff, m_i_off);
    check("R3 irq_xon", irq_xon, m_i_on);
    check("R6 pend_xoff", pend_xoff, m_p_off);
    check("R6 pend_xon", pend_xon, m_p_on);
    s_off = tx_slot && w_off;
    s_on  = tx_slot && !w_off && w_on;
    @(posedge clk);
    m_i_off = got_off;
    m_i_on  = got_on;
    if (!cfg_en)     m_far_stop = 1'b0;
    else if (got_off) m_far_stop = 1'b1;
    else if (got_on)  m_far_stop = 1'b0;
    if (s_off)      m_sent_stop = 1'b1;
    else if (s_on)  m_sent_stop = 1'b0;
    m_p_off = sw_send_xoff || (m_p_off && !s_off);
    m_p_on  = sw_send_xon  || (m_p_on  && !s_on);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    rx_valid = 0; rx_data = 0; sw_send_xon = 0; sw_send_xoff = 0;
    force_stop = 0; force_run = 0; tx_slot = 0; txq_valid = 0; txq_data = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    int lvl;
    void'($urandom(32'h1a2b3c));
    rst_n = 0; idle_inputs();
    cfg_en = 0; cfg_strip = 0; cfg_xon_char = 8'h11; cfg_xoff_char = 8'h13;
    cfg_hi_lsb = 8'h05; cfg_hi_msb = 2'd1; cfg_lo_lsb = 8'h20; cfg_lo_msb = 2'd0;
    rx_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R1: reset values
    check("R1 tx_load", tx_load, 0);
    check("R1 txq_pop", txq_pop, 0);
    check("R1 irq", {irq_xon, irq_xoff}, 0);
    check("R1 pend", {pend_xon, pend_xoff}, 0);
    check("R1 tx_halted", tx_halted, 0);
    @(negedge clk);

    // Directed: level above 0x105 with a slot -> stop char before data (R2, R7)
    cfg_en = 1; rx_level = 10'h106; tx_slot = 1; txq_valid = 1; txq_data = 8'hA5;
    #2;
    check("R2 directed stop char", tx_char, 8'h13);
    check("R7 directed no pop", txq_pop, 0);
    @(negedge clk);
    #2;
    check("R2 no second stop, data goes", tx_char, 8'hA5);
    @(negedge clk);
    // level below lower mark -> one resume (R2)
    rx_level = 10'h010;
    #2;
    check("R2 directed resume char", tx_char, 8'h11);
    @(negedge clk);
    // received stop with strip (R3, R5)
    idle_inputs(); cfg_strip = 1; rx_valid = 1; rx_data = 8'h13;
    #2;
    check("R5 directed strip", fifo_wr, 0);
    @(negedge clk);
    rx_valid = 0;
    #2;
    check("R3 directed irq_xoff", irq_xoff, 1);
    check("R3 directed halted", tx_halted, 1);
    @(negedge clk);

    // Resync the model with the design: reset both.
    rst_n = 0; idle_inputs(); cfg_en = 0;
    @(negedge clk);
    rst_n = 1;
    m_far_stop = 0; m_sent_stop = 0; m_p_on = 0; m_p_off = 0; m_i_on = 0; m_i_off = 0;

    lvl = 100;
    for (int ph = 0; ph < 40; ph++) begin
      int lo, hi;
      cfg_en    = (ph % 5) != 4;
      cfg_strip = $urandom_range(0, 1);
      cfg_xon_char  = (ph % 3 == 0) ? 8'h11 : 8'($urandom);
      cfg_xoff_char = (ph == 7) ? cfg_xon_char : ((ph % 3 == 0) ? 8'h13 : 8'($urandom));
      lo = $urandom_range(0, 600);
      hi = lo + $urandom_range(0, 300);
      {cfg_lo_msb, cfg_lo_lsb} = 10'(lo);
      {cfg_hi_msb, cfg_hi_lsb} = 10'(hi);
      for (int cy = 0; cy < 200; cy++) begin
        int r;
        lvl += $urandom_range(0, 16) - 8;
        if (lvl < 0) lvl = 0;
        if (lvl > 1023) lvl = 1023;
        rx_level = 10'(lvl);
        rx_valid = ($urandom_range(0, 9) < 3);
        r = $urandom_range(0, 2);
        rx_data  = (r == 0) ? cfg_xon_char : ((r == 1) ? cfg_xoff_char : 8'($urandom));
        tx_slot  = ($urandom_range(0, 3) == 0);
        txq_valid = $urandom_range(0, 1);
        txq_data  = 8'($urandom);
        sw_send_xon  = ($urandom_range(0, 40) == 0);
        sw_send_xoff = ($urandom_range(0, 40) == 0);
        force_stop   = ($urandom_range(0, 20) == 0);
        force_run    = ($urandom_range(0, 20) == 0);
        step();
      end
    end
    summary();
    $finish;
  end

endmodule